// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a small synchronous burst SRAM with flow-through reads. On every rising clock edge it looks at three chip enables, two address strobes, a burst-advance input, the write controls and a sleep input. From these it classifies the edge as one of six cycles: deselect, sleep, begin-read, begin-write, continue or suspend. A continue or suspend cycle becomes a read or a write depending on the write controls.

A burst covers an aligned group of four words. Only the two low address bits change during a burst, in either linear or interleaved order. One strobe serves the processor side and always starts a read. The other strobe serves a memory controller and can start a write. Read data comes out of the array combinationally from the registered burst address, so it is valid before the next edge. It reaches the data port only when the output enable (which is not clocked) allows it.

The data bus has three parts: a write-data input, a read-data output, and a `data_drive` flag that marks when the bus would be driven. Read data is zero whenever the bus is not driven.

Top module: `sync_burst_sram`

## Requirements
- R1: The part is selected only when `en1_n`=0, `en2`=1 and `en3_n`=0. A strobe-started cycle under any other enable combination is a deselect: nothing is written, and `data_drive` is 0 after that edge.
- R2: While `en1_n`=1, `cpu_stb_n` is ignored. With `ctl_stb_n`=0 the cycle is a deselect. With `ctl_stb_n`=1 the cycle is a continue or suspend.
- R3: `cpu_stb_n`=0 with a valid selection loads `addr` and starts a read, whatever the write controls are. The array is left unchanged.
- R4: `ctl_stb_n`=0 with `cpu_stb_n`=1 and a valid selection loads `addr`. It writes that word if the write term is active, and otherwise starts a read.
- R5: The write term is active when `all_wr_n`=0, or when `lane_gate_n`=0 and at least one bit of `lane_wr_n` is 0.
- R6: With both strobes inactive and `adv_n`=0, the burst advances one position and the cycle reads or writes according to the write term. With `adv_n`=1, the same address is used again.
- R7: The burst position n (0 to 3) replaces the two low bits of the loaded address a. With `order_sel`=0 they become (a+n) mod 4; with `order_sel`=1 they become a XOR n. The upper bits never change.
- R8: Byte lane i covers data bits [8i+7:8i]. With `all_wr_n`=0 every lane is written. Otherwise only the lanes whose `lane_wr_n` bit is 0 are written, and only when `lane_gate_n`=0.
- R9: While `nap`=1, no write occurs, the burst address is held, and `data_drive` is 0.
- R10: `data_drive` is 1 only after a read cycle, while `out_en_n`=0 and `nap`=0. It follows `out_en_n` without a clock and is 0 after any write cycle. `rd_data` is 0 whenever `data_drive` is 0.
- R11: After a read edge, `rd_data` holds the word at the burst address that edge applied, before the next edge.
- R12: While reset is applied, `data_drive` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en1_n | input | 1 | Primary chip enable, active low |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| nap | input | 1 | Sleep request, overrides all |
| cpu_stb_n | input | 1 | Processor address strobe, read-only start |
| ctl_stb_n | input | 1 | Controller address strobe |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_gate_n | input | 1 | Gate for per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Output enable, not clocked |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | External word address |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Read data, zero when not driven |
| data_drive | output | 1 | Data bus driven by the block |

## Verification
The most interesting overlap is a write attempt in the same cycle as a processor-strobe start. The bench provokes it by asserting `cpu_stb_n` together with `all_wr_n`, or with lane writes, against a word whose contents are known. It then judges the result by reading that word back: the value must be unchanged.

A second overlap is sleep falling inside a burst that carries write controls. The bench asserts `nap` there and then resumes the burst, and it expects the held address and the unchanged data.

A behavioural model, updated on every edge, predicts `data_drive` and `rd_data` across directed cases and a long mixed random run. The bench also toggles `out_en_n` between edges to confirm that the output gating needs no clock.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [2:0] {
    CYC_DESEL    = 3'd0,
    CYC_SLEEP    = 3'd1,
    CYC_BEGIN_RD = 3'd2,
    CYC_BEGIN_WR = 3'd3,
    CYC_CONT     = 3'd4,
    CYC_SUSP     = 3'd5
  } cyc_e;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             en1_n,
  input  logic             en2,
  input  logic             en3_n,
  input  logic             nap,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             adv_n,
  input  logic             all_wr_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  output cyc_e             cyc,
  output logic             wr_term,
  output logic [LANES-1:0] lane_sel
);

  logic selected;

  // lane selection: global write wins, then gated per-lane enables
  always_comb begin
    if (!all_wr_n)         lane_sel = '1;
    else if (!lane_gate_n) lane_sel = ~lane_wr_n;
    else                   lane_sel = '0;
    wr_term = |lane_sel;
  end

  assign selected = !en1_n && en2 && !en3_n;

  // cycle classification, sleep first, processor strobe only while en1_n low
  always_comb begin
    if (nap) begin
      cyc = CYC_SLEEP;
    end else if (!en1_n && !cpu_stb_n) begin
      cyc = selected ? CYC_BEGIN_RD : CYC_DESEL;
    end else if (!ctl_stb_n) begin
      if (!selected)    cyc = CYC_DESEL;
      else if (wr_term) cyc = CYC_BEGIN_WR;
      else              cyc = CYC_BEGIN_RD;
    end else if (!adv_n) begin
      cyc = CYC_CONT;
    end else begin
      cyc = CYC_SUSP;
    end
  end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [ADDR_W-1:0] held_addr
);

  localparam int POS_W = 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic              load_en, step_en;

  function automatic logic [ADDR_W-1:0] place(input logic [ADDR_W-1:0] b,
                                              input logic [POS_W-1:0]  p,
                                              input logic              ilv);
    logic [POS_W-1:0] low;
    low = ilv ? (b[POS_W-1:0] ^ p) : (b[POS_W-1:0] + p);
    return {b[ADDR_W-1:POS_W], low};
  endfunction

  assign load_en = (cyc == CYC_BEGIN_RD) || (cyc == CYC_BEGIN_WR);
  assign step_en = (cyc == CYC_CONT);

  always_comb begin
    base_d = base_q;
    pos_d  = pos_q;
    if (load_en) begin
      base_d = ext_addr;
      pos_d  = '0;
    end else if (step_en) begin
      pos_d  = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pos_q  <= '0;
    end else if (load_en || step_en) begin
      base_q <= base_d;
      pos_q  <= pos_d;
    end
  end

  assign cyc_addr  = place(base_d, pos_d, order_sel);
  assign held_addr = place(base_q, pos_q, order_sel);

  // R4: a strobe start lands on the external address
  p_begin_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (held_addr == $past(ext_addr)));

  // R6: suspend keeps burst state
  p_susp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_SUSP) |=> ($stable(base_q) && $stable(pos_q)));

  // R7: continue moves one position inside the group
  p_cont_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> ((base_q == $past(base_q)) && (pos_q == $past(pos_q) + 2'd1)));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic [LANES-1:0]         lane_we,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [LANES*LANE_W-1:0]  rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = store[rd_addr];
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en1_n,
  input  logic                    en2,
  input  logic                    en3_n,
  input  logic                    nap,
  input  logic                    cpu_stb_n,
  input  logic                    ctl_stb_n,
  input  logic                    adv_n,
  input  logic                    all_wr_n,
  input  logic                    lane_gate_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    out_en_n,
  input  logic                    order_sel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    data_drive
);

  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  cyc_e              cyc;
  logic              wr_term;
  logic [LANES-1:0]  lane_sel;
  logic [LANES-1:0]  lane_we_g;
  logic              do_write;
  logic [ADDR_W-1:0] cyc_addr, held_addr;
  logic [DATA_W-1:0] arr_data;
  logic              rd_q, rd_d;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  sbsram_decode #(.LANES(LANES)) u_decode (
    .en1_n       (en1_n),
    .en2         (en2),
    .en3_n       (en3_n),
    .nap         (nap),
    .cpu_stb_n   (cpu_stb_n),
    .ctl_stb_n   (ctl_stb_n),
    .adv_n       (adv_n),
    .all_wr_n    (all_wr_n),
    .lane_gate_n (lane_gate_n),
    .lane_wr_n   (lane_wr_n),
    .cyc         (cyc),
    .wr_term     (wr_term),
    .lane_sel    (lane_sel)
  );

  sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cyc       (cyc),
    .order_sel (order_sel),
    .ext_addr  (addr),
    .cyc_addr  (cyc_addr),
    .held_addr (held_addr)
  );

  always_comb begin
    do_write = core_rst_n && ((cyc == CYC_BEGIN_WR) ||
               (((cyc == CYC_CONT) || (cyc == CYC_SUSP)) && wr_term));
    lane_we_g = do_write ? lane_sel : '0;
    rd_d = (cyc == CYC_BEGIN_RD) ||
           (((cyc == CYC_CONT) || (cyc == CYC_SUSP)) && !wr_term);
  end

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .lane_we (lane_we_g),
    .wr_addr (cyc_addr),
    .wr_data (wr_data),
    .rd_addr (held_addr),
    .rd_data (arr_data)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) rd_q <= 1'b0;
    else             rd_q <= rd_d;
  end

  // output gating is combinational in out_en_n and nap
  assign data_drive = rd_q && !out_en_n && !nap;
  assign rd_data    = data_drive ? arr_data : '0;

  // R1: deselect leaves the bus undriven
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cyc == CYC_DESEL) |=> !data_drive);

  // R3: processor strobe never writes
  p_cpu_stb_read_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!en1_n && !cpu_stb_n) |-> (lane_we_g == '0));

  // R9: sleep blocks writes
  p_nap_nowrite_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    nap |-> (lane_we_g == '0));

  // R10: output enable masked after a write
  p_write_masks_oe_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    (lane_we_g != '0) |=> !data_drive);

endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;

  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 8;
  localparam int DW = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic en1_n, en2, en3_n, nap, cpu_stb_n, ctl_stb_n, adv_n;
  logic all_wr_n, lane_gate_n, out_en_n, order_sel;
  logic [LN-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          data_drive;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_base;
  int            m_pos;
  bit            m_rd;

  always #5 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
    .nap(nap), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
    .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
    .out_en_n(out_en_n), .order_sel(order_sel), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .data_drive(data_drive)
  );

  function automatic logic [AW-1:0] model_addr();
    int low;
    if (order_sel) low = (m_base % 4) ^ (m_pos % 4);
    else           low = ((m_base % 4) + m_pos) % 4;
    return AW'((m_base / 4) * 4 + low);
  endfunction

  function automatic void model_write(input logic [AW-1:0] a);
    for (int i = 0; i < LN; i++) begin
      if (!all_wr_n || (!lane_gate_n && !lane_wr_n[i]))
        m_mem[a][i*LW +: LW] = wr_data[i*LW +: LW];
    end
  endfunction

  function automatic void model_edge();
    bit sel, wr;
    sel = !en1_n && en2 && !en3_n;
    wr  = !all_wr_n || (!lane_gate_n && (lane_wr_n != '1));
    if (nap) begin
      m_rd = 0;
    end else if (!en1_n && !cpu_stb_n) begin
      if (sel) begin m_base = addr; m_pos = 0; m_rd = 1; end
      else m_rd = 0;
    end else if (!ctl_stb_n) begin
      if (sel) begin
        m_base = addr; m_pos = 0;
        if (wr) begin model_write(addr); m_rd = 0; end
        else m_rd = 1;
      end else m_rd = 0;
    end else begin
      if (!adv_n) m_pos = (m_pos + 1) % 4;
      if (wr) begin model_write(model_addr()); m_rd = 0; end
      else m_rd = 1;
    end
  endfunction

  task automatic check_out(input string tag);
    logic          exp_drv;
    logic [DW-1:0] exp_dat;
    exp_drv = m_rd && !out_en_n && !nap;
    exp_dat = exp_drv ? m_mem[model_addr()] : '0;
    compared++;
    if (data_drive !== exp_drv || rd_data !== exp_dat) begin
      mismatched++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, data_drive, rd_data, exp_drv, exp_dat);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic idle();
    en1_n = 1; en2 = 0; en3_n = 1; nap = 0;
    cpu_stb_n = 1; ctl_stb_n = 1; adv_n = 1;
    all_wr_n = 1; lane_gate_n = 1; lane_wr_n = '1;
  endtask

  task automatic pick();
    en1_n = 0; en2 = 1; en3_n = 0;
  endtask

  function automatic logic [DW-1:0] pattern(input int a);
    return {8'(a), 8'(~a), 8'(a + 8'h33), 8'(a ^ 8'h5A)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle();
    out_en_n = 0; order_sel = 0; addr = '0; wr_data = '0;
    rst_n = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_base = '0; m_pos = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    // R12: quiet bus during reset
    compared++;
    if (data_drive !== 1'b0 || rd_data !== '0) begin
      mismatched++;
      $display("FAIL R12: drive=%0b data=%h expected drive=0 data=0", data_drive, rd_data);
    end
    nap = 1;
    rst_n = 1;
    repeat (4) @(negedge clk);
    nap = 0;

    // R4 R5: fill the array through controller-strobe writes
    for (int a = 0; a < DEPTH; a++) begin
      idle(); pick(); ctl_stb_n = 0; all_wr_n = 0;
      addr = AW'(a); wr_data = pattern(a);
      step("R4");
    end

    // R3 R11: processor-strobe reads, flow-through
    idle(); pick(); cpu_stb_n = 0; addr = 6'd13; step("R11");
    idle(); pick(); cpu_stb_n = 0; addr = 6'd40; step("R3");

    // R6 R7: linear burst from offset 2
    order_sel = 0;
    idle(); pick(); cpu_stb_n = 0; addr = 6'd22; step("R7");
    for (int k = 0; k < 5; k++) begin idle(); adv_n = 0; step("R7"); end
    // R6: suspend holds
    idle(); adv_n = 1; step("R6");
    idle(); adv_n = 1; step("R6");
    // R7: interleaved burst from offset 3
    order_sel = 1;
    idle(); pick(); ctl_stb_n = 0; addr = 6'd31; step("R7");
    for (int k = 0; k < 4; k++) begin idle(); adv_n = 0; step("R7"); end
    order_sel = 0;

    // R3: write attempted with processor strobe is dropped
    idle(); pick(); cpu_stb_n = 0; all_wr_n = 0; addr = 6'd9; wr_data = 32'hDEADBEEF; step("R3");
    idle(); pick(); cpu_stb_n = 0; ctl_stb_n = 0; lane_gate_n = 0; lane_wr_n = 4'b0000;
    addr = 6'd9; wr_data = 32'hFEEDFACE; step("R3");
    idle(); pick(); cpu_stb_n = 0; addr = 6'd9; step("R3");

    // R8: lanes 0 and 2 written (lane_wr_n = 1010)
    idle(); pick(); ctl_stb_n = 0; lane_gate_n = 0; lane_wr_n = 4'b1010;
    addr = 6'd17; wr_data = 32'h11223344; step("R8");
    idle(); pick(); cpu_stb_n = 0; addr = 6'd17; step("R8");
    // R5: lane enables without gate make a read
    idle(); pick(); ctl_stb_n = 0; lane_gate_n = 1; lane_wr_n = 4'b0000;
    addr = 6'd18; wr_data = 32'h0; step("R5");
    // R5: gate without lanes is a read too
    idle(); pick(); ctl_stb_n = 0; lane_gate_n = 0; lane_wr_n = 4'b1111;
    addr = 6'd19; step("R5");

    // R6: continue write burst, then read it back
    idle(); pick(); ctl_stb_n = 0; all_wr_n = 0; addr = 6'd44; wr_data = 32'hA0A0A0A0; step("R6");
    idle(); adv_n = 0; all_wr_n = 0; wr_data = 32'hA1A1A1A1; step("R6");
    idle(); adv_n = 1; lane_gate_n = 0; lane_wr_n = 4'b0111; wr_data = 32'hB2B2B2B2; step("R6");
    idle(); pick(); cpu_stb_n = 0; addr = 6'd45; step("R6");

    // R1: bad enable combinations
    idle(); en1_n = 0; en2 = 0; en3_n = 0; cpu_stb_n = 0; addr = 6'd3; step("R1");
    idle(); en1_n = 0; en2 = 1; en3_n = 1; ctl_stb_n = 0; all_wr_n = 0;
    addr = 6'd3; wr_data = 32'h0BAD0BAD; step("R1");
    idle(); pick(); cpu_stb_n = 0; addr = 6'd3; step("R1");
    // R2: en1_n high, processor strobe ignored
    idle(); en1_n = 1; en2 = 1; en3_n = 0; cpu_stb_n = 0; ctl_stb_n = 0; addr = 6'd50; step("R2");
    idle(); pick(); cpu_stb_n = 0; addr = 6'd4; step("R2");
    idle(); en1_n = 1; cpu_stb_n = 0; adv_n = 0; addr = 6'd60; step("R2");

    // R9: sleep inside a write-carrying burst
    idle(); pick(); cpu_stb_n = 0; addr = 6'd8; step("R9");
    idle(); nap = 1; adv_n = 0; all_wr_n = 0; wr_data = 32'h55AA55AA; step("R9");
    idle(); nap = 1; pick(); ctl_stb_n = 0; all_wr_n = 0; addr = 6'd1; step("R9");
    idle(); adv_n = 1; step("R9");
    idle(); pick(); cpu_stb_n = 0; addr = 6'd9; step("R9");

    // R10: output enable acts between edges
    idle(); pick(); cpu_stb_n = 0; addr = 6'd27; step("R10");
    out_en_n = 1; #1 check_out("R10");
    out_en_n = 0; #1 check_out("R10");
    idle(); pick(); ctl_stb_n = 0; all_wr_n = 0; addr = 6'd27; wr_data = 32'h12345678; step("R10");

    // mixed random run
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      idle();
      en1_n = (r[3:0] == 4'd0); en2 = (r[7:4] != 4'd0); en3_n = (r[11:8] == 4'd0);
      nap = (r[15:12] == 4'd0);
      cpu_stb_n = r[16] | r[17];
      ctl_stb_n = r[18] | r[19];
      adv_n = r[20];
      all_wr_n = r[21] | r[22];
      lane_gate_n = r[23];
      lane_wr_n = r[27:24];
      out_en_n = (r[29:28] == 2'd0);
      order_sel = r[30];
      addr = AW'($urandom);
      wr_data = $urandom;
      step(r[31] ? "R6" : "R4");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule